// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Datapath

This block is a small 32-bit processor core that completes each instruction in one clock. It covers the arithmetic register-to-register group (add, subtract, and, or, set-less-than), add-immediate, word load, word store and branch-if-equal. All of the work for an instruction happens in one combinational sweep. Instruction fetch, field slicing, register read, ALU, data-memory read, write-back selection and next-address selection run every cycle. At the rising edge only three things change: the program counter, one register-file entry and one data-memory word.

The core never branches in logic. Both the sequential address and the branch target come from two adders that always run, and the data memory is read on every cycle whether or not the result is used. Multiplexers steered by an internal opcode/funct decoder then pick the live values. Instruction memory and data memory are internal word arrays. The program is written through a plain load port while reset is held, and it starts from address 0 once reset is released. A debug read port gives combinational access to any register. No path in this block carries a stream, so no pin has a valid/ready handshake. Every pin is a plain control or status signal, and the core has no back-pressure.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the program counter reads 0x00000000 and every register reads zero through the debug port. No register or data-memory write happens during reset.
- R2: When no branch is taken, the program counter advances by exactly 4 at every rising edge.
- R3: R-type instructions (opcode 0x00) write rs op rt into register rd (bits [15:11]). The funct codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or and 0x2A signed set-less-than (result 1 or 0). Example: word 0x00221820 with register 1 = 5 and register 2 = 10 gives register 3 = 15, and the PC moves on by 4 after one clock.
- R4: Add-immediate (opcode 0x08) writes rs plus the immediate into register rt (bits [20:16]). The immediate is bits [15:0], sign-extended by copying bit 15.
- R5: Store (opcode 0x2B) writes the rt value to the data-memory word rs + sign-extended offset. Load (opcode 0x23) returns that word into register rt. The word index is taken from bits [N+1:2] of the address. Only a store writes memory.
- R6: Branch-if-equal (opcode 0x04) with rs == rt sets the PC to PC + 4 + (sign-extended offset << 2), and this holds for negative offsets too. With rs != rt the PC becomes PC + 4.
- R7: Register 0 always reads zero. A write that targets it has no effect.
- R8: An unknown opcode writes no register and no memory, and the PC still advances by 4.
- R9: A word written through the load port at word index k while reset is held is the instruction fetched when the PC equals 4·k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset; holds PC at 0 and clears registers |
| imem_we | input | 1 | Instruction-memory load strobe |
| imem_addr | input | $clog2(IMEM_WORDS) | Word index to load |
| imem_wdata | input | 32 | Instruction word to load |
| pc_o | output | 32 | Current program counter |
| dbg_raddr | input | 5 | Debug register index |
| dbg_rdata | output | 32 | Combinational value of the debug register |

## Verification
A single program runs from reset. It exercises all five R-type functions with mixed-sign operands, so that a wrong funct decode or an unsigned compare gives a different result. Add-immediate with a negative value separates sign extension from zero extension. A store followed by a load to the same word shows that the address path and the write-back selection both work. The program also contains a not-taken branch, a taken forward branch that skips two writes, and a backward branch to itself. Together these separate the Branch-AND-zero selection from an unconditional taken or an unconditional fall-through. A write aimed at register 0 and an unknown opcode that names a live rt field show whether either of them leaks into the register file.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    mem_rd;
    logic    wb_from_mem;
    logic    rf_we;
    logic    mem_we;
    logic    is_branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.rf_we     = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.rf_we  = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.rf_we    = 1'b1;
      end
      OP_LW: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.mem_rd      = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.rf_we       = 1'b1;
      end
      OP_SW: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] sum, diff;
  logic         lt;

  assign sum  = a + b;
  assign diff = a - b;
  assign lt   = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      ALU_SUB: y = diff;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, lt};
      default: y = sum;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [$clog2(N)-1:0] ra_a,
  input  logic [$clog2(N)-1:0] ra_b,
  input  logic [$clog2(N)-1:0] ra_dbg,
  output logic [W-1:0]         rd_a,
  output logic [W-1:0]         rd_b,
  output logic [W-1:0]         rd_dbg,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] wa,
  input  logic [W-1:0]         wd
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a   = regs[ra_a];
  assign rd_b   = regs[ra_b];
  assign rd_dbg = regs[ra_dbg];

  // R7
  rf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          imem_we,
  input  logic [$clog2(IMEM_WORDS)-1:0] imem_addr,
  input  logic [31:0]                   imem_wdata,
  output logic [31:0]                   pc_o,
  input  logic [4:0]                    dbg_raddr,
  output logic [31:0]                   dbg_rdata
);
  localparam int IA = $clog2(IMEM_WORDS);
  localparam int DA = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_off, br_tgt;
  logic [31:0]     instr;
  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // Instruction memory: load port plus combinational fetch
  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_addr] <= imem_wdata;
  end
  assign instr = imem[pc_q[IA+1:2]];

  // Field slicing
  logic [5:0]      opcode, funct;
  logic [4:0]      rs, rt, rd, wr_idx;
  logic [XLEN-1:0] imm_ext;
  assign opcode  = instr[31:26];
  assign rs      = instr[25:21];
  assign rt      = instr[20:16];
  assign rd      = instr[15:11];
  assign funct   = instr[5:0];
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  ctrl_t ctrl;
  sc_decoder u_dec (.opcode(opcode), .funct(funct), .ctrl(ctrl));

  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, mem_y, wb_val;
  logic            alu_zero, take;

  assign wr_idx = ctrl.dst_is_rd ? rd : rt;

  sc_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(rs), .ra_b(rt), .ra_dbg(dbg_raddr),
    .rd_a(rs_val), .rd_b(rt_val), .rd_dbg(dbg_rdata),
    .we(ctrl.rf_we), .wa(wr_idx), .wd(wb_val)
  );

  assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero)
  );

  // Data memory: read every cycle, write only on store
  logic [DA-1:0] d_idx;
  assign d_idx = alu_y[DA+1:2];
  assign mem_y = dmem[d_idx];
  always_ff @(posedge clk) begin
    if (rst_n && ctrl.mem_we) dmem[d_idx] <= rt_val;
  end

  assign wb_val = ctrl.wb_from_mem ? mem_y : alu_y;

  // Next-PC: both adders always run, AND gate steers the mux
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_off   = {imm_ext[XLEN-3:0], 2'b00};
  assign br_tgt   = pc_plus4 + br_off;
  assign take     = ctrl.is_branch & alu_zero;
  assign pc_next  = take ? br_tgt : pc_plus4;

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end
  assign pc_o = pc_q;

  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(take)) |-> pc_q == $past(pc_q) + 32'd4);

  // R6
  br_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(take)) |-> pc_q == $past(pc_q) + 32'd4 + $past(br_off));

  // R5
  dm_we_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mem_we |-> opcode == OP_SW);

  // R8
  rf_we_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.rf_we |-> (opcode == OP_RTYPE || opcode == OP_ADDI || opcode == OP_LW));

  // R1
  pc_reset_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> pc_q == '0 || rst_n);
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_addr = '0;
  logic [31:0] imem_wdata = '0;
  logic [31:0] pc_o;
  logic [4:0]  dbg_raddr = '0;
  logic [31:0] dbg_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] val;
    int          idx;
    string       req;
  } exp_t;

  exp_t pc_q[$];
  exp_t reg_q[$];

  always #4 clk = ~clk;

  sc_core i_sc_core (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .pc_o(pc_o), .dbg_raddr(dbg_raddr),
    .dbg_rdata(dbg_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic load(int k, logic [31:0] w);
    @(negedge clk);
    imem_we = 1'b1; imem_addr = 6'(k); imem_wdata = w;
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  task automatic push_pc(logic [31:0] v, string req);
    pc_q.push_back('{val: v, idx: 0, req: req});
  endtask

  task automatic push_reg(int i, logic [31:0] v, string req);
    reg_q.push_back('{val: v, idx: i, req: req});
  endtask

  // Watchdog
  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t e;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", pc_o, 32'h0);
    for (int i = 0; i < 32; i += 7) begin
      dbg_raddr = 5'(i); #1;
      check("R1", dbg_rdata, 32'h0);
    end

    // R9: program loaded while reset is held
    load(0,  32'h20010005); // addi r1,r0,5
    load(1,  32'h2002000A); // addi r2,r0,10
    load(2,  32'h00221820); // add r3,r1,r2
    load(3,  32'h00222022); // sub r4,r1,r2
    load(4,  32'h00222824); // and r5
    load(5,  32'h00223025); // or r6
    load(6,  32'h0081382A); // slt r7,r4,r1
    load(7,  32'h2008FFFC); // addi r8,r0,-4
    load(8,  32'hAC030008); // sw r3,8(r0)
    load(9,  32'h8C090008); // lw r9,8(r0)
    load(10, 32'h20000007); // addi r0,r0,7
    load(11, 32'h10220005); // beq r1,r2 not taken
    load(12, 32'hFC0A0063); // unknown opcode, rt=10
    load(13, 32'h10690002); // beq r3,r9 taken -> 64
    load(14, 32'h200A0063); // skipped
    load(15, 32'h200A0062); // skipped
    load(16, 32'h200B0001); // addi r11,r0,1
    load(17, 32'h0024602A); // slt r12,r1,r4
    load(18, 32'h1000FFFF); // beq r0,r0,-1 self loop
    check("R1", pc_o, 32'h0);

    // Expected PC trace
    for (int k = 0; k <= 13; k++) push_pc(32'(4 * k), (k == 12) ? "R8" : "R2");
    push_pc(32'd64, "R6");
    push_pc(32'd68, "R2");
    push_pc(32'd72, "R2");
    push_pc(32'd72, "R6");
    push_pc(32'd72, "R6");

    // Expected register file
    push_reg(0,  32'h0,        "R7");
    push_reg(1,  32'd5,        "R4");
    push_reg(2,  32'd10,       "R4");
    push_reg(3,  32'd15,       "R3");
    push_reg(4,  32'hFFFFFFFB, "R3");
    push_reg(5,  32'h0,        "R3");
    push_reg(6,  32'd15,       "R3");
    push_reg(7,  32'd1,        "R3");
    push_reg(8,  32'hFFFFFFFC, "R4");
    push_reg(9,  32'd15,       "R5");
    push_reg(10, 32'h0,        "R8");
    push_reg(11, 32'd1,        "R6");
    push_reg(12, 32'h0,        "R3");

    @(negedge clk);
    rst_n = 1'b1;

    // Monitor: PC trace, one item per cycle
    while (pc_q.size() > 0) begin
      e = pc_q.pop_front();
      check(e.req, pc_o, e.val);
      @(negedge clk);
    end

    // Monitor: register contents
    while (reg_q.size() > 0) begin
      e = reg_q.pop_front();
      dbg_raddr = 5'(e.idx); #1;
      check(e.req, dbg_rdata, e.val);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule